// File: doc/BRIEF.md
# Register Write-Port Scheduler with Reservations

This block is the issue-control logic in front of a small register bank that has a single write port. Each functional unit it serves has a fixed pipeline latency. When an instruction issues, the scheduler therefore knows the exact cycle in which its result will reach the register bank. It books that cycle on a delivery timeline and reserves the destination register. Only the delay of the arithmetic is modelled; no data passes through the block.

Each cycle the issue stage presents one candidate instruction: a unit selector, two source indices and a destination index. The scheduler grants issue, in the same cycle and combinationally, only when three conditions hold. No source the unit reads may still be waiting for a pending result. The destination may not already be waiting. The result may not land in a write-port cycle that is already booked. The timeline later raises a write-back strobe with the destination index, and the reservation on that register is then released.

Top module: `regport_sched`

## Requirements
- R1: After synchronous active-low reset, no write-back strobe is raised and every register is free, so a valid request is granted in the first cycle after reset release.
- R2: Unit code 0 (register transfer) has latency 1, code 1 (address add) 2, code 2 (scalar add) 3, code 3 (address multiply) 6. A request granted in cycle c raises `wb_valid` in cycle c+latency, with `wb_idx` equal to its destination.
- R3: A request whose unit reads a source register with a pending result is refused. Units 1, 2 and 3 read both sources.
- R4: Unit code 0 reads only `req_src0`. A pending result on `req_src1` does not block it.
- R5: A request whose destination already has a pending result is refused.
- R6: A request whose result would arrive in a cycle in which a write-back is already booked is refused. Requests whose results land in distinct cycles are all granted.
- R7: A reservation stays in force through the cycle that carries its write-back strobe. A reader of that register is refused in the strobe cycle and granted in the next cycle.
- R8: Units are fully pipelined. Requests to one unit on consecutive cycles, with free operands, are all granted, and their strobes follow on consecutive cycles.
- R9: With `req_valid` low, `issue_grant` is low and nothing is booked or reserved.
- R10: At most one write-back strobe occurs per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A candidate instruction is presented this cycle |
| req_unit | input | 2 | Functional unit selector (codes in R2) |
| req_src0 | input | 3 | First source register index |
| req_src1 | input | 3 | Second source register index |
| req_dst | input | 3 | Destination register index |
| issue_grant | output | 1 | Candidate issues this cycle |
| wb_valid | output | 1 | A result is written to the bank this cycle |
| wb_idx | output | 3 | Register written when `wb_valid` is high |

## Verification
The bench targets the cycle of the write-back strobe relative to each reader. A design that released reservations one cycle early would grant the reader in the strobe cycle, and one that released them late would refuse it in the following cycle. Write-port collisions are provoked by starting units of different latency so that all of them aim at the same arrival cycle. A timeline indexed off by one would either let two strobes share a cycle or refuse a legal request. Operand-count handling is tested by a transfer whose unused second source is reserved, and back-to-back issue to a single unit tests that the unit accepts a new request every cycle.

// File: rtl/regsched_pkg.sv
// Package: shared unit encoding and a constant helper for the write-port
// scheduler. Assumes exactly four functional unit classes.
package regsched_pkg;

    typedef enum logic [1:0] {
        UNIT_XFER = 2'd0,
        UNIT_AADD = 2'd1,
        UNIT_SADD = 2'd2,
        UNIT_AMUL = 2'd3
    } unit_e;

    // Largest of four latencies, used to size the delivery timeline.
    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rs_lat_decode.sv
// Module: maps a unit selector to its fixed result latency and tells whether
// the unit reads a second operand. Assumes all latencies are >= 1.
module rs_lat_decode
    import regsched_pkg::*;
#(
    parameter int LAT_XFER = 1,
    parameter int LAT_AADD = 2,
    parameter int LAT_SADD = 3,
    parameter int LAT_AMUL = 6,
    parameter int LAT_W    = 3
) (
    input  logic [1:0]       unit_sel,
    output logic [LAT_W-1:0] lat,
    output logic             reads_src1
);

    // Decode the unit code into latency and operand count.
    always_comb begin
        reads_src1 = 1'b1;
        unique case (unit_e'(unit_sel))
            UNIT_XFER: begin
                lat        = LAT_W'(LAT_XFER);
                reads_src1 = 1'b0;
            end
            UNIT_AADD: lat = LAT_W'(LAT_AADD);
            UNIT_SADD: lat = LAT_W'(LAT_SADD);
            UNIT_AMUL: lat = LAT_W'(LAT_AMUL);
            default:   lat = LAT_W'(LAT_XFER);
        endcase
    end

endmodule

// File: rtl/rs_wb_timeline.sv
// Module: delivery timeline for the single write port. Slot k holds a write
// that lands k cycles after the current one; slot 0 drives the strobe.
// Assumes the caller never books an occupied slot and books with 1 <= lat <= MAX_LAT.
module rs_wb_timeline #(
    parameter int MAX_LAT = 6,
    parameter int IDX_W   = 3,
    parameter int LAT_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               book_en,
    input  logic [LAT_W-1:0]   book_lat,
    input  logic [IDX_W-1:0]   book_dst,
    output logic [MAX_LAT-1:0] slot_busy,
    output logic               wb_valid,
    output logic [IDX_W-1:0]   wb_idx
);

    logic [MAX_LAT-1:0] busy_q;
    logic [IDX_W-1:0]   dst_q [MAX_LAT];

    for (genvar k = 0; k < MAX_LAT; k++) begin : g_slot
        if (k == MAX_LAT - 1) begin : g_top
            // Top slot: only a fresh booking of the longest latency fills it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    busy_q[k] <= 1'b0;
                    dst_q[k]  <= '0;
                end else if (book_en && book_lat == LAT_W'(k + 1)) begin
                    busy_q[k] <= 1'b1;
                    dst_q[k]  <= book_dst;
                end else begin
                    busy_q[k] <= 1'b0;
                end
            end
        end else begin : g_mid
            // Lower slots: take a fresh booking or advance from the slot above.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    busy_q[k] <= 1'b0;
                    dst_q[k]  <= '0;
                end else if (book_en && book_lat == LAT_W'(k + 1)) begin
                    busy_q[k] <= 1'b1;
                    dst_q[k]  <= book_dst;
                end else begin
                    busy_q[k] <= busy_q[k+1];
                    dst_q[k]  <= dst_q[k+1];
                end
            end
        end
    end

    assign slot_busy = busy_q;
    assign wb_valid  = busy_q[0];
    assign wb_idx    = dst_q[0];

    // R2: every booking asks for a latency the timeline can hold.
    assert_lat_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        book_en |-> (book_lat != '0 && int'(book_lat) <= MAX_LAT));

    // R2: a booking appears in the slot matching its latency one cycle later.
    assert_book_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        book_en |=> busy_q[$past(book_lat) - 1'b1]);

endmodule

// File: rtl/rs_resv_table.sv
// Module: one reservation bit per register. Set on issue of a writer,
// cleared at the edge that ends its write-back cycle. Assumes set and clear
// never name the same register in one cycle.
module rs_resv_table #(
    parameter int NREG  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [NREG-1:0]  resv
);

    for (genvar i = 0; i < NREG; i++) begin : g_bit
        // Track whether register i awaits a pending result.
        always_ff @(posedge clk) begin
            if (!rst_n)
                resv[i] <= 1'b0;
            else if (set_en && set_idx == IDX_W'(i))
                resv[i] <= 1'b1;
            else if (clr_en && clr_idx == IDX_W'(i))
                resv[i] <= 1'b0;
        end
    end

    // R5: a register is never reserved twice.
    assert_no_double_reserve_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !resv[set_idx]);

    // R7: a write-back always retires an outstanding reservation.
    assert_clear_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> resv[clr_idx]);

endmodule

// File: rtl/regport_sched.sv
// Module: top of the write-port scheduler. Grants issue when sources and
// destination are free and the result's arrival cycle is unbooked, then books
// the timeline and reserves the destination. Assumes the issue stage drops or
// holds a refused request on its own.
module regport_sched
    import regsched_pkg::*;
#(
    parameter int NREG     = 8,
    parameter int LAT_XFER = 1,
    parameter int LAT_AADD = 2,
    parameter int LAT_SADD = 3,
    parameter int LAT_AMUL = 6,
    parameter int IDX_W    = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_unit,
    input  logic [IDX_W-1:0] req_src0,
    input  logic [IDX_W-1:0] req_src1,
    input  logic [IDX_W-1:0] req_dst,
    output logic             issue_grant,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_idx
);

    localparam int MAX_LAT = max_of4(LAT_XFER, LAT_AADD, LAT_SADD, LAT_AMUL);
    localparam int LAT_W   = $clog2(MAX_LAT + 1);
    localparam int EXT_W   = 1 << LAT_W;

    logic [LAT_W-1:0]   lat;
    logic               reads_src1;
    logic [MAX_LAT-1:0] slot_busy;
    logic [EXT_W-1:0]   busy_ext;
    logic [NREG-1:0]    resv;
    logic               src_hold, dst_hold, port_clash;

    rs_lat_decode #(
        .LAT_XFER(LAT_XFER), .LAT_AADD(LAT_AADD),
        .LAT_SADD(LAT_SADD), .LAT_AMUL(LAT_AMUL), .LAT_W(LAT_W)
    ) u_dec (
        .unit_sel   (req_unit),
        .lat        (lat),
        .reads_src1 (reads_src1)
    );

    rs_wb_timeline #(.MAX_LAT(MAX_LAT), .IDX_W(IDX_W), .LAT_W(LAT_W)) u_tl (
        .clk       (clk),
        .rst_n     (rst_n),
        .book_en   (issue_grant),
        .book_lat  (lat),
        .book_dst  (req_dst),
        .slot_busy (slot_busy),
        .wb_valid  (wb_valid),
        .wb_idx    (wb_idx)
    );

    rs_resv_table #(.NREG(NREG), .IDX_W(IDX_W)) u_resv (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (issue_grant),
        .set_idx (req_dst),
        .clr_en  (wb_valid),
        .clr_idx (wb_idx),
        .resv    (resv)
    );

    // Widen the timeline so any latency code indexes a defined bit.
    assign busy_ext = {{(EXT_W - MAX_LAT){1'b0}}, slot_busy};

    // Hazard evaluation and grant for the presented request.
    always_comb begin
        src_hold    = resv[req_src0] | (reads_src1 & resv[req_src1]);
        dst_hold    = resv[req_dst];
        // Slot lat holds what will sit in slot lat-1 after this edge.
        port_clash  = busy_ext[lat];
        issue_grant = req_valid & ~src_hold & ~dst_hold & ~port_clash;
    end

    // R9: no grant without a request.
    assert_idle_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !issue_grant);

    // R3: a granted request never reads a register awaiting its result.
    assert_src_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |-> !resv[req_src0]);

    // R5: the destination of a granted request is reserved in the next cycle.
    assert_dst_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |=> resv[$past(req_dst)]);

    // R7: the register written by a strobe is free in the next cycle.
    assert_release_after_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !resv[$past(wb_idx)]);

    // R10: a strobe only ever writes a register that was reserved for it.
    assert_wb_owned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> resv[wb_idx]);

endmodule

// File: tb/regport_sched_tb.sv
// Scoreboard bench: the driver pushes each expected write-back with its due
// cycle; a monitor at every falling edge pops and compares.
module regport_sched_tb;
    import regsched_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [1:0] req_unit;
    logic [2:0] req_src0, req_src1, req_dst;
    logic       issue_grant, wb_valid;
    logic [2:0] wb_idx;

    typedef struct {
        int    due;
        int    dst;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regport_sched u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_unit(req_unit),
        .req_src0(req_src0), .req_src1(req_src1), .req_dst(req_dst),
        .issue_grant(issue_grant), .wb_valid(wb_valid), .wb_idx(wb_idx)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int unit_lat(input logic [1:0] u);
        case (u)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 3;
            default: return 6;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Present one request for one cycle and check the grant decision.
    task automatic do_req(input bit v, input logic [1:0] u, input logic [2:0] s0,
                          input logic [2:0] s1, input logic [2:0] d,
                          input bit exp_grant, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = v; req_unit = u; req_src0 = s0; req_src1 = s1; req_dst = d;
        #1;
        check(issue_grant == exp_grant, tag, "issue_grant", issue_grant, exp_grant);
        if (exp_grant) begin
            e.due = cyc + unit_lat(u);
            e.dst = d;
            e.tag = tag;
            sb_q.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: every strobe must match a booked item due in this cycle.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            int hit;
            hit = -1;
            foreach (sb_q[i]) if (sb_q[i].due == cyc) hit = i;
            if (wb_valid) begin
                if (hit < 0) begin
                    check(1'b0, "R2", "unexpected wb_valid", 1, 0);
                end else begin
                    check(int'(wb_idx) == sb_q[hit].dst, sb_q[hit].tag, "wb_idx",
                          wb_idx, sb_q[hit].dst);
                    sb_q.delete(hit);
                end
            end else if (hit >= 0) begin
                check(1'b0, sb_q[hit].tag, "missing wb_valid", 0, 1);
                sb_q.delete(hit);
            end
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_unit = '0;
        req_src0 = '0; req_src1 = '0; req_dst = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        check(wb_valid == 1'b0, "R1", "wb_valid after reset", wb_valid, 0);
        do_req(1'b1, 2'd0, 3'd6, 3'd6, 3'd7, 1'b1, "R1");
        // R9: no request, no grant, no booking.
        do_req(1'b0, 2'd2, 3'd0, 3'd0, 3'd5, 1'b0, "R9");
        idle(8);

        // R2: each unit latency in isolation.
        do_req(1'b1, 2'd0, 3'd0, 3'd0, 3'd1, 1'b1, "R2"); idle(8);
        do_req(1'b1, 2'd1, 3'd0, 3'd0, 3'd2, 1'b1, "R2"); idle(8);
        do_req(1'b1, 2'd2, 3'd0, 3'd0, 3'd3, 1'b1, "R2"); idle(8);
        do_req(1'b1, 2'd3, 3'd0, 3'd0, 3'd4, 1'b1, "R2"); idle(8);

        // Hazard sequence around a multiply into r5 (strobe 6 cycles later).
        do_req(1'b1, 2'd3, 3'd0, 3'd0, 3'd5, 1'b1, "R3");
        do_req(1'b1, 2'd1, 3'd5, 3'd0, 3'd2, 1'b0, "R3");   // src0 pending
        do_req(1'b1, 2'd1, 3'd0, 3'd5, 3'd2, 1'b0, "R3");   // src1 pending
        do_req(1'b1, 2'd0, 3'd0, 3'd5, 3'd6, 1'b1, "R4");   // transfer ignores src1
        do_req(1'b1, 2'd2, 3'd0, 3'd0, 3'd5, 1'b0, "R5");   // dst pending
        idle(1);
        do_req(1'b1, 2'd0, 3'd5, 3'd0, 3'd7, 1'b0, "R7");   // strobe cycle
        do_req(1'b1, 2'd0, 3'd5, 3'd0, 3'd7, 1'b1, "R7");   // next cycle
        idle(8);

        // R6: three units aiming at the multiply's arrival cycle.
        do_req(1'b1, 2'd3, 3'd0, 3'd0, 3'd1, 1'b1, "R6");
        do_req(1'b1, 2'd2, 3'd0, 3'd0, 3'd4, 1'b1, "R6");   // distinct arrival
        idle(1);
        do_req(1'b1, 2'd2, 3'd0, 3'd0, 3'd2, 1'b0, "R6");
        do_req(1'b1, 2'd1, 3'd0, 3'd0, 3'd2, 1'b0, "R6");
        do_req(1'b1, 2'd0, 3'd0, 3'd0, 3'd2, 1'b0, "R6");
        do_req(1'b1, 2'd0, 3'd0, 3'd0, 3'd3, 1'b1, "R6");
        idle(8);

        // R8: back-to-back issue to one unit.
        do_req(1'b1, 2'd1, 3'd0, 3'd0, 3'd1, 1'b1, "R8");
        do_req(1'b1, 2'd1, 3'd0, 3'd0, 3'd2, 1'b1, "R8");
        do_req(1'b1, 2'd1, 3'd0, 3'd0, 3'd3, 1'b1, "R8");
        do_req(1'b1, 2'd1, 3'd0, 3'd0, 3'd4, 1'b1, "R8");
        idle(12);

        // R10: every booked strobe arrived, one per cycle.
        check(sb_q.size() == 0, "R10", "pending write-backs", sb_q.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule